// File: doc/BRIEF.md
# Keyboard Character Input Port

This block is a bus-slave peripheral that takes character codes from a simple parallel keyboard and presents them to a processor through two word-aligned registers. The keyboard drives a keypress strobe and an 8-bit code. On the leading edge of the strobe the code is captured and a ready flag is raised. The processor either polls the ready flag or takes an interrupt when that is enabled, and then reads the code.

Reading the code register is the acknowledge. It drops the ready flag and the overrun flag in the same step. A keypress that arrives while the previous code is still unread raises the overrun flag. The only control bit is the interrupt enable, which software can write. The interrupt request is the AND of interrupt enable and ready.

The strobe must already be synchronous to the block clock. Address decoding above the register offset is done outside the block.

Top module: `kbd_in_port`

## Requirements
- R1: Offset 0 (`reg_sel_i`=0) reads the last captured code in bits 7:0. It is loaded only on a keypress leading edge, and a bus write to offset 0 leaves it unchanged.
- R2: Offset 4 (`reg_sel_i`=1) reads ready in bit 0, overrun error in bit 6 and interrupt enable in bit 7. The following read bits are 0: bits 31:8 of both registers and bits 5:1 of the status word. `rdata_o` is 0 whenever `rd_i` is low.
- R3: A cycle in which `key_strobe_i` is 1 after being 0 in the previous cycle is a leading edge. After that clock edge, ready reads 1 and the new code is held.
- R4: A strobe held high over many cycles counts as one keypress. A data read during the held strobe clears ready, and ready stays cleared.
- R5: A leading edge while ready is 1 sets the error bit. The error bit takes the value of ready from before that same edge updates it.
- R6: A read of offset 0 clears ready and error at the next clock edge. A read of offset 4 changes neither.
- R7: A write to offset 4 loads interrupt enable from `wdata_i` bit 7. All other write bits are ignored.
- R8: `irq_o` is 1 exactly while interrupt enable and ready are both 1.
- R9: `rst_ni` low clears ready, error, interrupt enable, the code register and the strobe history.
- R10: A data read and a leading edge in the same cycle are resolved in favour of the keypress. Ready stays 1, the new code is captured, and error takes the ready value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_strobe_i | input | 1 | Keypress strobe, synchronous level |
| key_code_i | input | 8 | Character code from the keyboard |
| reg_sel_i | input | 1 | Register select: 0 = offset 0 (data), 1 = offset 4 (status/control) |
| rd_i | input | 1 | Bus read strobe |
| wr_i | input | 1 | Bus write strobe |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data (combinational, 0 when no read) |
| irq_o | output | 1 | Interrupt request |

## Verification
A keypress leading edge and the acknowledging read of the code register can land in the same clock cycle. In that case one event sets ready and the other clears it. The bench creates this collision on purpose, once with ready already set and once with it clear. It then reads the status word to confirm that ready survived, that error took the prior ready value, and that the code register holds the new code. A behavioural reference model is compared against `rdata_o` and `irq_o` on every cycle, including randomly generated cycles in which both events collide.

// File: rtl/kbd_in_pkg.sv
package kbd_in_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned CODE_W  = 8;
  localparam int unsigned RDY_BIT = 0;
  localparam int unsigned ERR_BIT = 6;
  localparam int unsigned IE_BIT  = 7;

  typedef struct packed {
    logic ready;
    logic err;
    logic ie;
  } kbd_flags_t;
endpackage

// File: rtl/kbd_edge_det.sv
module kbd_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  // R4: a held level yields no second edge
  p_single_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/kbd_code_reg.sv
module kbd_code_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_o <= '0;
    else if (load_i) code_o <= code_i;
  end

  p_code_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(code_o));
  p_code_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> code_o == $past(code_i));
endmodule

// File: rtl/kbd_flags.sv
module kbd_flags (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rise_i,
  input  logic                    ack_i,
  input  logic                    ie_we_i,
  input  logic                    ie_d_i,
  output kbd_in_pkg::kbd_flags_t  flags_o
);
  kbd_in_pkg::kbd_flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      if (rise_i) begin
        q.err   <= q.ready;   // sample before update
        q.ready <= 1'b1;
      end else if (ack_i) begin
        q.err   <= 1'b0;
        q.ready <= 1'b0;
      end
      if (ie_we_i) q.ie <= ie_d_i;
    end
  end

  assign flags_o = q;

  p_rdy_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> flags_o.ready);
  p_err_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && flags_o.ready) |=> flags_o.err);
  p_err_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !flags_o.ready) |=> !flags_o.err);
  p_ack_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !rise_i) |=> (!flags_o.ready && !flags_o.err));
  p_ie_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_we_i |=> $stable(flags_o.ie));
  p_err_implies_rdy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.err |-> flags_o.ready);
endmodule

// File: rtl/kbd_rdata_mux.sv
module kbd_rdata_mux #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned CODE_W = 8
) (
  input  logic                   rd_i,
  input  logic                   sel_i,
  input  logic [CODE_W-1:0]      code_i,
  input  kbd_in_pkg::kbd_flags_t flags_i,
  output logic [BUS_W-1:0]       rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (sel_i) begin
        rdata_o[kbd_in_pkg::RDY_BIT] = flags_i.ready;
        rdata_o[kbd_in_pkg::ERR_BIT] = flags_i.err;
        rdata_o[kbd_in_pkg::IE_BIT]  = flags_i.ie;
      end else begin
        rdata_o[CODE_W-1:0] = code_i;
      end
    end
  end
endmodule

// File: rtl/kbd_in_port.sv
module kbd_in_port
  import kbd_in_pkg::*;
#(
  parameter int unsigned DATA_W = BUS_W,
  parameter int unsigned KEY_W  = CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_strobe_i,
  input  logic [KEY_W-1:0]  key_code_i,
  input  logic              reg_sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic             rise;
  logic             ack;
  logic             ie_we;
  logic [KEY_W-1:0] code_q;
  kbd_flags_t       flags;

  assign ack   = rd_i & ~reg_sel_i;
  assign ie_we = wr_i & reg_sel_i;

  kbd_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (key_strobe_i),
    .rise_o  (rise)
  );

  kbd_code_reg #(.W(KEY_W)) u_code (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rise),
    .code_i (key_code_i),
    .code_o (code_q)
  );

  kbd_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .ack_i   (ack),
    .ie_we_i (ie_we),
    .ie_d_i  (wdata_i[IE_BIT]),
    .flags_o (flags)
  );

  kbd_rdata_mux #(.BUS_W(DATA_W), .CODE_W(KEY_W)) u_mux (
    .rd_i    (rd_i),
    .sel_i   (reg_sel_i),
    .code_i  (code_q),
    .flags_i (flags),
    .rdata_o (rdata_o)
  );

  assign irq_o = flags.ie & flags.ready;

  // R10: keypress beats acknowledge
  p_collide_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && rise) |=> (flags.ready && code_q == $past(key_code_i)));
  p_idle_bus_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

// File: tb/kbd_in_port_tb.sv
module kbd_in_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [7:0]  kcode = '0;
  logic        sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit       m_rdy, m_err, m_ie, m_prev;
  bit [7:0] m_code;

  always #2.5 clk = ~clk;

  kbd_in_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .key_strobe_i(strobe), .key_code_i(kcode),
    .reg_sel_i(sel), .rd_i(rd), .wr_i(wr), .wdata_i(wd),
    .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_rdata();
    if (!rd) return 32'h0;
    if (!sel) return {24'h0, m_code};
    return {24'h0, m_ie, m_err, 5'h0, m_rdy};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rdy = 0; m_err = 0; m_ie = 0; m_prev = 0; m_code = '0;
  endtask

  // drive one cycle: inputs set after negedge, compare, then advance
  task automatic step(input logic s, input logic [7:0] kc, input logic r,
                      input logic w, input logic sl, input logic [31:0] d,
                      input string tag);
    bit rise;
    strobe = s; kcode = kc; rd = r; wr = w; sel = sl; wd = d;
    #1;
    chk(tag, rdata, exp_rdata());
    chk({tag, "/R8 irq"}, {31'h0, irq}, {31'h0, m_ie & m_rdy});
    @(posedge clk);
    rise = s && !m_prev;
    if (rise) begin
      m_err = m_rdy; m_rdy = 1; m_code = kc;
    end else if (r && !sl) begin
      m_rdy = 0; m_err = 0;
    end
    if (w && sl) m_ie = d[7];
    m_prev = s;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 8'h00, 0, 0, 0, 32'h0, tag);
  endtask

  task automatic rd_stat(input string tag);
    step(0, 8'h00, 1, 0, 1, 32'h0, tag);
  endtask

  task automatic rd_data(input string tag);
    step(0, 8'h00, 1, 0, 0, 32'h0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R9: reset state
    rd = 1; sel = 1; #1;
    chk("R9 status in reset", rdata, 32'h0);
    chk("R9 irq in reset", {31'h0, irq}, 32'h0);
    rd = 0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_data("R9 code after reset");

    // R3: single press
    step(1, 8'h41, 0, 0, 0, 32'h0, "R3 press");
    step(0, 8'h00, 0, 0, 0, 32'h0, "R3");
    rd_stat("R3 ready");
    rd_stat("R6 status read keeps ready");

    // R1: write to data offset ignored
    step(0, 8'h00, 0, 1, 0, 32'hFFFF_FF55, "R1 write off0");
    rd_data("R1 code kept");

    // R7 / R8
    step(0, 8'h00, 0, 1, 1, 32'h0000_0080, "R7 ie set");
    rd_stat("R8 irq on");
    step(0, 8'h00, 0, 1, 1, 32'hFFFF_FF7F, "R7 ie clear, other bits ignored");
    rd_stat("R7 ie off");
    step(0, 8'h00, 0, 1, 1, 32'h0000_00FF, "R7 ie set again");

    // R6: acknowledge
    rd_data("R6 ack read");
    rd_stat("R6 ready cleared");
    idle("R8 irq off after ack");

    // R4: long strobe, read in the middle
    step(1, 8'h62, 0, 0, 0, 32'h0, "R4 press");
    step(1, 8'h63, 0, 0, 0, 32'h0, "R4 held");
    step(1, 8'h64, 1, 0, 0, 32'h0, "R4 read during hold");
    step(1, 8'h65, 0, 0, 0, 32'h0, "R4 held after read");
    rd_stat("R4 no re-set");
    rd_data("R4 code stays first");
    step(0, 8'h00, 0, 0, 0, 32'h0, "R4 release");

    // R5: overrun
    step(1, 8'h31, 0, 0, 0, 32'h0, "R5 first");
    idle("R5");
    rd_stat("R5 no err yet");
    step(1, 8'h32, 0, 0, 0, 32'h0, "R5 second");
    idle("R5");
    rd_stat("R5 err set");
    rd_data("R5 newest code");
    rd_stat("R6 err cleared");

    // R10: collisions
    step(1, 8'h51, 1, 0, 0, 32'h0, "R10 collide rdy0");
    idle("R10");
    rd_stat("R10 ready kept, err 0");
    step(1, 8'h52, 1, 0, 0, 32'h0, "R10 collide rdy1");
    idle("R10");
    rd_stat("R10 ready kept, err 1");
    rd_data("R10 new code");

    // R9: mid-run reset
    step(1, 8'h77, 0, 0, 0, 32'h0, "R9 pre");
    rst_n = 1'b0; model_reset(); #1;
    rd = 1; sel = 1; #1;
    chk("R9 status after reset", rdata, 32'h0);
    rd = 0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_data("R9 code cleared");

    // random traffic, model compared every cycle
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv = $urandom;
      step(rv[0] & rv[1], rv[15:8], rv[2], rv[3] & rv[4], rv[5], {rv[31:16], rv[23:8]}, "R2 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule